// File: doc/BRIEF.md
# Dual-Mode I2C Clock Timing Generator

This block produces the serial clock waveform for an I2C master, together with two one-cycle strobes that tell the master when to change the data line and when to sample it. It takes a 12-bit main divider and a 12-bit low-period count. The main divider arrives as a 10-bit field and a 2-bit extension, and the two are joined into one value. The master starts and stops the clock with a single run control.

There are two timing modes. In symmetric mode, each clock period is four equal phases of the main divider. A fixed settling delay of 15 clocks is added to the high half, to cover the input filters on the line. In asymmetric mode, the high half is the main divider plus the same 15-clock delay, and the low half is set by the separate low-period count. This mode lets fast-mode buses run with roughly 40% high and 60% low time. A divider or low count of zero is treated as one, so the clock never stalls. When run is low, the counters clear and the clock line is released high.

Top module: `scl_timer`

## Requirements
- R1: The effective main divider D is {div_ext, div_lo}, with div_ext in bits 11:10 and div_lo in bits 9:0.
- R2: With hl_mode=0, SCL stays low for 2*D clock cycles and high for 2*D+15 clock cycles.
- R3: With hl_mode=1, SCL stays low for L clock cycles, where L is low_cnt, and high for D+15 clock cycles.
- R4: A D or an L of zero behaves as the value one.
- R5: The largest divider, 4095, gives a low phase of 8190 cycles and a high phase of 8205 cycles in symmetric mode, with no counter wrap.
- R6: tick_sda pulses for exactly one cycle per low phase. It falls on cycle floor(low_len/2), counting from 0 at the first cycle in which SCL is low.
- R7: tick_sample pulses for exactly one cycle per high phase. It falls on cycle floor(high_len/2), counting from 0 at the first cycle in which SCL is high.
- R8: While run is low, scl_o is 1 and neither tick fires. After the first clock edge that samples run as 1, SCL is low and a new low phase begins.
- R9: scl_low is 1 exactly when scl_o is 0.
- R10: With hl_mode=0, low_cnt has no effect on the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables clock generation; low releases SCL high |
| div_lo | input | 10 | Low 10 bits of the main divider |
| div_ext | input | 2 | Top 2 bits of the main divider |
| low_cnt | input | 12 | Low-phase length in asymmetric mode |
| hl_mode | input | 1 | 1 selects asymmetric high/low timing |
| scl_o | output | 1 | Serial clock level |
| scl_low | output | 1 | High while SCL is driven low |
| tick_sda | output | 1 | Mid-low-phase strobe for changing the data line |
| tick_sample | output | 1 | Mid-high-phase strobe for sampling the data line |

## Verification
The assertions assume that the divider, low count and mode inputs stay constant while run is high. The phase lengths and the low-time bound they check are only meaningful under that condition. The stimulus changes these inputs only while run is low, and it holds run low for several cycles between settings. Phase lengths and tick positions are measured at the ports on a full period taken after the first low phase.

// File: rtl/scl_timer.sv
module scl_timer #(
  parameter int DW    = 12,
  parameter int LO_W  = 10,
  parameter int FILT  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [LO_W-1:0]   div_lo,
  input  logic [DW-LO_W-1:0] div_ext,
  input  logic [DW-1:0]     low_cnt,
  input  logic              hl_mode,
  output logic              scl_o,
  output logic              scl_low,
  output logic              tick_sda,
  output logic              tick_sample
);
  localparam int CW = DW + 2;

  logic [DW-1:0] div_raw;
  logic [CW-1:0] div_eff, low_eff, low_len, high_len, cnt_q, cur_len;
  logic          scl_q, active_q, last;

  assign div_raw  = {div_ext, div_lo};
  assign div_eff  = (div_raw == '0) ? CW'(1) : CW'(div_raw);
  assign low_eff  = (low_cnt == '0) ? CW'(1) : CW'(low_cnt);
  assign low_len  = hl_mode ? low_eff : (div_eff << 1);
  assign high_len = hl_mode ? (div_eff + CW'(FILT)) : ((div_eff << 1) + CW'(FILT));
  assign cur_len  = scl_q ? high_len : low_len;
  assign last     = (cnt_q >= cur_len - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q    <= 1'b1;
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!run) begin
      scl_q    <= 1'b1;
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!active_q) begin
      scl_q    <= 1'b0;
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (last) begin
      scl_q <= ~scl_q;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign scl_o       = scl_q;
  assign scl_low     = ~scl_q;
  assign tick_sda    = active_q && !scl_q && (cnt_q == (low_len >> 1));
  assign tick_sample = active_q && scl_q && (cnt_q == (high_len >> 1));
endmodule

// File: rtl/scl_timer_chk.sv
module scl_timer_chk #(
  parameter int DW = 12
) (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic scl_o,
  input logic scl_low,
  input logic tick_sda,
  input logic tick_sample
);
  localparam int MAXLOW = 2 * ((1 << DW) - 1);
  logic [DW+1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= '0;
    else if (!scl_o) low_run <= low_run + 1'b1;
    else low_run <= '0;
  end

  a_r8_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (scl_o && !tick_sda && !tick_sample));
  a_r6_sda_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    tick_sda |-> scl_low);
  a_r7_sample_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    tick_sample |-> (scl_o && !scl_low));
  a_r6_sda_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick_sda |=> !tick_sda);
  a_r7_sample_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick_sample |=> !tick_sample);
  a_r5_low_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= (DW+2)'(MAXLOW));
endmodule

bind scl_timer scl_timer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .scl_o(scl_o), .scl_low(scl_low),
  .tick_sda(tick_sda), .tick_sample(tick_sample)
);

// File: tb/scl_timer_bench.sv
module scl_timer_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, hl_mode = 1'b0;
  logic [9:0] div_lo = '0;
  logic [1:0] div_ext = '0;
  logic [11:0] low_cnt = '0;
  logic scl_o, scl_low, tick_sda, tick_sample;
  int checks = 0, failures = 0;

  always #(CLK_P/2) clk = ~clk;

  scl_timer u_scl_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .div_lo(div_lo), .div_ext(div_ext),
    .low_cnt(low_cnt), .hl_mode(hl_mode), .scl_o(scl_o), .scl_low(scl_low),
    .tick_sda(tick_sda), .tick_sample(tick_sample)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure(input int dl, input int de, input int lc, input bit hl,
                         input int exp_lo, input int exp_hi, input string tag);
    int nlo, nhi, psda, psmp, nsda, nsmp, bad;
    @(negedge clk);
    run = 1'b0; div_lo = 10'(dl); div_ext = 2'(de); low_cnt = 12'(lc); hl_mode = hl;
    repeat (4) @(negedge clk);
    run = 1'b1;
    @(negedge clk);
    chk(scl_o == 1'b0, {tag, " R8 start low"}, scl_o, 0);
    while (scl_o == 1'b0) @(negedge clk);
    while (scl_o == 1'b1) @(negedge clk);
    nlo = 0; nhi = 0; psda = -1; psmp = -1; nsda = 0; nsmp = 0; bad = 0;
    while (scl_o == 1'b0) begin
      if (scl_low != 1'b1) bad++;
      if (tick_sda) begin nsda++; psda = nlo; end
      if (tick_sample) nsmp++;
      nlo++;
      @(negedge clk);
    end
    while (scl_o == 1'b1) begin
      if (scl_low != 1'b0) bad++;
      if (tick_sample) begin nsmp++; psmp = nhi; end
      if (tick_sda) nsda++;
      nhi++;
      @(negedge clk);
    end
    chk(nlo == exp_lo, {tag, " low length"}, nlo, exp_lo);
    chk(nhi == exp_hi, {tag, " high length"}, nhi, exp_hi);
    chk(nsda == 1 && psda == exp_lo / 2, {tag, " R6 sda tick position"}, psda, exp_lo / 2);
    chk(nsmp == 1 && psmp == exp_hi / 2, {tag, " R7 sample tick position"}, psmp, exp_hi / 2);
    chk(bad == 0, {tag, " R9 scl_low flag"}, bad, 0);
  endtask

  task automatic t_reset;
    chk(scl_o == 1'b1 && !tick_sda && !tick_sample, "R8 reset idle", scl_o, 1);
  endtask

  task automatic t_stop;
    int seen;
    @(negedge clk);
    run = 1'b0;
    seen = 0;
    repeat (20) begin
      @(negedge clk);
      if (scl_o != 1'b1 || tick_sda || tick_sample) seen++;
    end
    chk(seen == 0, "R8 stopped stays released", seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    measure(5, 0, 0, 0, 10, 25, "R2 symmetric div5");
    measure(3, 1, 7, 0, 2054, 2069, "R1 R10 joined divider");
    measure(3, 1, 900, 0, 2054, 2069, "R10 low count ignored");
    measure(20, 0, 30, 1, 30, 35, "R3 asymmetric");
    measure(0, 0, 0, 1, 1, 16, "R4 zero asymmetric");
    measure(0, 0, 0, 0, 2, 17, "R4 zero symmetric");
    measure(1023, 3, 0, 0, 8190, 8205, "R5 max divider");
    t_stop();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule